// File: doc/BRIEF.md
# Modem Line Control and Status Block

This block keeps the modem-control byte for a serial port and assembles the modem-status byte from four incoming handshake lines: clear-to-send, data-set-ready, ring and carrier. The incoming lines are active-low and asynchronous. Each passes through its own synchroniser before its level is captured and any change is detected. The control byte drives four active-low outputs: terminal-ready, request-to-send and two auxiliary pins.

The status byte carries the present level of every line and a change flag for every line. A change flag stays set until the host reads the status byte. The ring line sets its flag only when a ring ends, and not when it starts. A separate output reports that at least one change flag is set. A self-test mode feeds the control bits back into the status bits in place of the external lines. It also parks the output pins in their inactive state.

A host writes the control byte through a one-cycle write strobe and can read it back at any time. The status byte is always visible on its output. A one-cycle read strobe marks the status byte as consumed.

Top module: `modem_lines`

## Requirements
- R1: After reset the control byte reads 0x00, all four output pins are high, the status byte reads 0x00 and the change output is low.
- R2: A write stores bits 4..0 of the write data at the next rising edge. Bits 7..5 of the control byte always read 0, whatever is written.
- R3: Outside self-test, control bit 0 drives `dtr_n` low, bit 1 drives `rts_n` low, bit 2 drives `aux1_n` low and bit 3 drives `aux2_n` low. Each pin changes at the same edge that stores the write. For example, 0x08 drives only `aux2_n` low, 0x09 also drives `dtr_n` low, and 0x0A drives `rts_n` and `aux2_n` low.
- R4: Status bits 7, 6, 5 and 4 show carrier, ring, data-set-ready and clear-to-send. Each bit is 1 while its pin is low. A pin change reaches the status byte at the third rising edge after it is applied.
- R5: Status bits 3, 1 and 0 are the change flags for carrier, data-set-ready and clear-to-send. A flag is set when its line changes in either direction and stays set until a status read.
- R6: Status bit 2 is set only when the ring line goes from asserted to released, which is status bit 6 falling from 1 to 0. A new ring assertion leaves bit 2 clear.
- R7: When `msr_rd` is high for one cycle, the status byte in that cycle still shows the flags. The edge that ends the cycle clears all four flags.
- R8: A line change that is detected at the same edge that ends a read cycle leaves its flag set after the read.
- R9: `msr_pend` is high exactly when at least one of status bits 3..0 is set.
- R10: Control bit 4 selects self-test. In self-test the status inputs come from the control bits instead of the external pins: clear-to-send from bit 1, data-set-ready from bit 0, ring from bit 2 and carrier from bit 3. The new values appear one edge after the control write, the external pins have no effect, and change flags follow the same rules as in R5 and R6.
- R11: While self-test is selected, all four output pins are held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mcr_we | input | 1 | Control byte write strobe |
| mcr_wdata | input | 8 | Control byte write data |
| mcr_rdata | output | 8 | Control byte read-back |
| msr_rd | input | 1 | Status byte read strobe, clears the change flags |
| msr_rdata | output | 8 | Status byte |
| msr_pend | output | 1 | At least one change flag is set |
| cts_n | input | 1 | Clear-to-send line, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready line, active low, asynchronous |
| ri_n | input | 1 | Ring line, active low, asynchronous |
| dcd_n | input | 1 | Carrier line, active low, asynchronous |
| dtr_n | output | 1 | Terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| aux1_n | output | 1 | First auxiliary pin, active low |
| aux2_n | output | 1 | Second auxiliary pin, active low |

## Verification
The assertions assume that reset is held from time zero through the first clock edge. They also assume that read and write strobes are clean single-cycle levels. The external lines may change at any time: the assertions examine only the synchronised values, so metastability is never judged. The stimulus changes the modem lines and the strobes only on falling edges. It holds every line level for at least four cycles, so each level passes through the synchronisers. It keeps the external lines released during reset, so no flags are set spuriously when reset ends.

// File: rtl/modem_pkg.sv
package modem_pkg;
  localparam int REG_W  = 8;
  localparam int LINES  = 4;

  // line index inside the four-bit status vectors
  localparam int L_CTS = 0;
  localparam int L_DSR = 1;
  localparam int L_RI  = 2;
  localparam int L_DCD = 3;

  // control byte bit positions
  localparam int C_DTR  = 0;
  localparam int C_RTS  = 1;
  localparam int C_AUX1 = 2;
  localparam int C_AUX2 = 3;
  localparam int C_LOOP = 4;

  localparam logic [REG_W-1:0] CTRL_MASK = 8'h1F;
  // lines whose flag is set on any change (ring uses trailing edge only)
  localparam logic [LINES-1:0] ANY_EDGE  = 4'b1011;
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= RST_VAL;
          else     stg[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= RST_VAL;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/modem_ctrl.sv
module modem_ctrl
  import modem_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] ctrl_q,
  output logic [3:0]       pins_n   // {aux2, aux1, rts, dtr}
);
  logic [REG_W-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (we) ctrl_d = wdata & CTRL_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      pins_n <= 4'hF;
    end else begin
      ctrl_q <= ctrl_d;
      pins_n <= ctrl_d[C_LOOP] ? 4'hF : ~ctrl_d[C_AUX2:C_DTR];
    end
  end

  // R2
  wr_store_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> ctrl_q[C_LOOP:0] == $past(wdata[C_LOOP:0]));
  // R11
  loop_pins_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[C_LOOP] |-> pins_n == 4'hF);
  // R3
  pins_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[C_LOOP] |-> pins_n == ~ctrl_q[C_AUX2:C_DTR]);
endmodule

// File: rtl/modem_status.sv
module modem_status
  import modem_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             loop_en,
  input  logic [LINES-1:0] loop_lines,  // asserted-high, index order L_*
  input  logic [LINES-1:0] ext_lines,   // asserted-high, synchronised
  input  logic             rd,
  output logic [REG_W-1:0] msr,
  output logic             pend
);
  logic [LINES-1:0] sel;
  logic [LINES-1:0] cur_q;
  logic [LINES-1:0] delta_q;
  logic [LINES-1:0] delta_d;
  logic [LINES-1:0] hit;
  logic             pend_q;

  assign sel = loop_en ? loop_lines : ext_lines;

  always_comb begin
    for (int i = 0; i < LINES; i++) begin
      if (ANY_EDGE[i]) hit[i] = cur_q[i] ^ sel[i];
      else             hit[i] = cur_q[i] & ~sel[i];
    end
    delta_d = (rd ? '0 : delta_q) | hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q   <= '0;
      delta_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      cur_q   <= sel;
      delta_q <= delta_d;
      pend_q  <= |delta_d;
    end
  end

  assign msr  = {cur_q, delta_q};
  assign pend = pend_q;

  // R5
  sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> ((delta_q & $past(delta_q)) == $past(delta_q)));
  // R5
  change_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (((cur_q ^ $past(cur_q)) & ANY_EDGE & ~delta_q) == '0));
  // R6
  ring_lead_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(cur_q[L_RI]) && $past(rd)) |-> !delta_q[L_RI]);
  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && sel == cur_q) |=> delta_q == '0);
  // R9
  pend_or_chk: assert property (@(posedge clk) disable iff (rst)
    pend_q == (delta_q != '0));
  // R10
  loop_src_chk: assert property (@(posedge clk) disable iff (rst)
    loop_en |=> cur_q == $past(loop_lines));
endmodule

// File: rtl/modem_lines.sv
module modem_lines
  import modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mcr_we,
  input  logic [7:0] mcr_wdata,
  output logic [7:0] mcr_rdata,
  input  logic       msr_rd,
  output logic [7:0] msr_rdata,
  output logic       msr_pend,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  output logic       dtr_n,
  output logic       rts_n,
  output logic       aux1_n,
  output logic       aux2_n
);
  logic [LINES-1:0] raw_n;
  logic [LINES-1:0] sync_n;
  logic [LINES-1:0] loop_lines;
  logic [REG_W-1:0] ctrl_q;
  logic [3:0]       pins_n;

  assign raw_n = {dcd_n, ri_n, dsr_n, cts_n};

  modem_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (raw_n),
    .dout (sync_n)
  );

  modem_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .we     (mcr_we),
    .wdata  (mcr_wdata),
    .ctrl_q (ctrl_q),
    .pins_n (pins_n)
  );

  // self-test routing: carrier<-aux2, ring<-aux1, dsr<-dtr, cts<-rts
  assign loop_lines = {ctrl_q[C_AUX2], ctrl_q[C_AUX1], ctrl_q[C_DTR], ctrl_q[C_RTS]};

  modem_status u_stat (
    .clk        (clk),
    .rst        (rst),
    .loop_en    (ctrl_q[C_LOOP]),
    .loop_lines (loop_lines),
    .ext_lines  (~sync_n),
    .rd         (msr_rd),
    .msr        (msr_rdata),
    .pend       (msr_pend)
  );

  assign mcr_rdata = ctrl_q;
  assign dtr_n     = pins_n[C_DTR];
  assign rts_n     = pins_n[C_RTS];
  assign aux1_n    = pins_n[C_AUX1];
  assign aux2_n    = pins_n[C_AUX2];

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(mcr_we) |-> mcr_rdata[7:5] == 3'b000);
endmodule

// File: tb/modem_lines_test.sv
`timescale 1ns/1ps
module modem_lines_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mcr_we = 1'b0;
  logic [7:0] mcr_wdata = '0;
  logic [7:0] mcr_rdata;
  logic       msr_rd = 1'b0;
  logic [7:0] msr_rdata;
  logic       msr_pend;
  logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
  logic       dtr_n, rts_n, aux1_n, aux2_n;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  modem_lines uut (
    .clk(clk), .rst(rst), .mcr_we(mcr_we), .mcr_wdata(mcr_wdata),
    .mcr_rdata(mcr_rdata), .msr_rd(msr_rd), .msr_rdata(msr_rdata),
    .msr_pend(msr_pend), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n),
    .dcd_n(dcd_n), .dtr_n(dtr_n), .rts_n(rts_n), .aux1_n(aux1_n),
    .aux2_n(aux2_n)
  );

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] pins();
    return {4'h0, aux2_n, aux1_n, rts_n, dtr_n};
  endfunction

  task automatic wr(logic [7:0] v);
    mcr_we = 1'b1; mcr_wdata = v;
    tick();
    mcr_we = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    msr_rd = 1'b1;
    v = msr_rdata;
    tick();
    msr_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "mcr", mcr_rdata, 8'h00);
    chk("R1", "pins", pins(), 8'h0F);
    chk("R1", "msr", msr_rdata, 8'h00);
    chk("R1", "pend", {7'b0, msr_pend}, 8'h00);
  endtask

  task automatic t_ctrl();
    wr(8'hEF);
    chk("R2", "reserved masked", mcr_rdata, 8'h0F);
    chk("R3", "all pins low", pins(), 8'h00);
    wr(8'h08);
    chk("R2", "mcr 08", mcr_rdata, 8'h08);
    chk("R3", "released", pins(), 8'h07);
    wr(8'h09);
    chk("R3", "dtr on", pins(), 8'h06);
    wr(8'h0A);
    chk("R3", "rts on", pins(), 8'h05);
    wr(8'h00);
    chk("R3", "cleared", pins(), 8'h0F);
  endtask

  task automatic t_lines();
    logic [7:0] v;
    cts_n = 1'b0;
    tick(2);
    chk("R4", "cts before sync", msr_rdata, 8'h00);
    tick();
    chk("R4", "cts after sync", msr_rdata, 8'h11);
    chk("R9", "pend set", {7'b0, msr_pend}, 8'h01);
    dsr_n = 1'b0; dcd_n = 1'b0;
    tick(4);
    chk("R5", "three lines", msr_rdata, 8'hBB);
    rd(v);
    chk("R7", "read value", v, 8'hBB);
    chk("R7", "after read", msr_rdata, 8'hB0);
    chk("R9", "pend clear", {7'b0, msr_pend}, 8'h00);
    cts_n = 1'b1; dsr_n = 1'b1; dcd_n = 1'b1;
    tick(4);
    chk("R5", "release sets flags", msr_rdata, 8'h0B);
    tick(3);
    chk("R5", "flags sticky", msr_rdata, 8'h0B);
    rd(v);
    chk("R7", "cleared", msr_rdata, 8'h00);
  endtask

  task automatic t_ring();
    logic [7:0] v;
    ri_n = 1'b0;
    tick(4);
    chk("R6", "ring start no flag", msr_rdata, 8'h40);
    chk("R9", "no pend", {7'b0, msr_pend}, 8'h00);
    ri_n = 1'b1;
    tick(4);
    chk("R6", "ring end flag", msr_rdata, 8'h04);
    chk("R9", "pend", {7'b0, msr_pend}, 8'h01);
    rd(v);
    chk("R7", "ring cleared", msr_rdata, 8'h00);
  endtask

  task automatic t_pulse();
    logic [7:0] v;
    cts_n = 1'b0; tick(4);
    cts_n = 1'b1; tick(4);
    chk("R5", "two changes one flag", msr_rdata, 8'h01);
    rd(v);
    chk("R7", "pulse cleared", msr_rdata, 8'h00);
  endtask

  task automatic t_loop();
    logic [7:0] v;
    wr(8'h10);
    chk("R11", "pins parked", pins(), 8'h0F);
    tick();
    chk("R10", "loop idle", msr_rdata, 8'h00);
    cts_n = 1'b0;
    tick(4);
    chk("R10", "external ignored", msr_rdata, 8'h00);
    wr(8'h12);
    chk("R11", "pins parked rts", pins(), 8'h0F);
    tick();
    chk("R10", "rts to cts", msr_rdata, 8'h11);
    wr(8'h14);
    tick();
    chk("R10", "aux1 to ring", msr_rdata, 8'h41);
    wr(8'h10);
    tick();
    chk("R10", "ring trailing", msr_rdata, 8'h05);
    rd(v);
    wr(8'h19);
    tick();
    chk("R10", "dtr/aux2 to dsr/dcd", msr_rdata, 8'hAA);
    rd(v);
    chk("R7", "loop cleared", msr_rdata, 8'hA0);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    wr(8'h18);
    tick();
    chk("R10", "dsr drop", msr_rdata, 8'h82);
    wr(8'h1A);
    rd(v);
    chk("R7", "read shows flag", v, 8'h82);
    chk("R8", "change kept", msr_rdata, 8'h91);
    chk("R9", "pend kept", {7'b0, msr_pend}, 8'h01);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick();
    t_reset();
    t_ctrl();
    t_lines();
    t_ring();
    t_pulse();
    t_loop();
    t_collide();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule